// File: doc/BRIEF.md
# Handshaked Bidirectional Byte Port

This block moves single bytes between a processor and an external device over an eight-bit parallel link. Each direction has its own handshake and its own one-byte buffer.

On the receive side, the device drives a byte and then raises a strobe. The port captures the byte and raises a ready line toward the device. Ready stays high until the processor reads the byte. On the transmit side, a processor write loads the transmit buffer and raises a buffer-full line toward the device. The device raises an acknowledge once it has taken the byte, and that acknowledge empties the buffer.

Both device-side control inputs are asynchronous. Each passes through a synchroniser and is detected on its rising edge. The port has two interrupt lines, each with its own mask bit. One reports that a received byte is waiting. The other reports that the transmit buffer has emptied.

The processor side is a synchronous select/write interface with a combinational read path and three registers:
- address 0: data
- address 1: status
- address 2: interrupt mask

Top module: `duplex_byte_port`

## Requirements
- R1: A rising strobe, seen after two synchroniser flops, with the receive buffer empty captures `dev_din` into the receive buffer and raises `dev_rdy` within four clock edges.
- R2: A processor read of address 0 returns the received byte, and `dev_rdy` is low from the next clock edge.
- R3: A rising strobe while the receive buffer is full leaves the held byte unchanged and sets a sticky overrun flag, status bit 2. Writing a 1 to status bit 2 (address 1) clears the flag.
- R4: A processor write to address 0 with the transmit buffer empty loads the byte onto `dev_dout` and raises `dev_bfull` on the next clock edge.
- R5: A synchronised rising acknowledge while `dev_bfull` is high clears `dev_bfull` and sets the transmit-empty pending flag, status bit 3.
- R6: A processor write to address 0 while `dev_bfull` is high is ignored, and `dev_dout` keeps the earlier byte.
- R7: `irq_rx` equals receive-full AND mask bit 0 (address 2), so it falls once the byte is read.
- R8: `irq_tx` equals transmit-empty pending AND mask bit 1 (address 2). An accepted data write clears the pending flag.
- R9: `dev_oe` is high exactly while `dev_bfull` is high or the synchronised acknowledge is high.
- R10: After reset, `dev_rdy`, `dev_bfull`, `dev_oe`, `irq_rx`, `irq_tx`, all status bits and the mask register are 0.
- R11: The status register at address 1 reads as follows: bit 0 is receive full, bit 1 is transmit full, bit 2 is overrun, bit 3 is transmit-empty pending, and the upper bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 1 | Register access this cycle |
| cpu_wr | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | 2 | Register address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data (combinational) |
| irq_rx | output | 1 | Receive byte waiting interrupt |
| irq_tx | output | 1 | Transmit buffer emptied interrupt |
| dev_din | input | DATA_W | Byte from device |
| dev_stb | input | 1 | Device strobe, asynchronous |
| dev_rdy | output | 1 | Port ready (receive buffer holds the byte) |
| dev_dout | output | DATA_W | Byte to device |
| dev_bfull | output | 1 | Transmit buffer full toward device |
| dev_ack | input | 1 | Device acknowledge, asynchronous |
| dev_oe | output | 1 | Pad output enable |

## Verification
Some rules relate one cycle to the next, and the assertions check these on every cycle:
- a blocked strobe never alters the held byte and always sets overrun;
- a read always drops ready;
- an accepted write always loads the byte;
- an acknowledge always empties the buffer and sets pending;
- the output enable always covers buffer-full.

Other behaviour only the bench scenarios can show. These scenarios cover the end-to-end byte values through both handshakes, the latency through the synchronisers, the status bit layout, the overrun clear, the mask gating of both interrupts, and the enable staying high while the device still holds acknowledge.

// File: rtl/dbp_pkg.sv
package dbp_pkg;
  localparam int unsigned ADDR_DATA = 0;
  localparam int unsigned ADDR_STAT = 1;
  localparam int unsigned ADDR_MASK = 2;
  localparam int unsigned STAT_W    = 4;
  localparam int unsigned OVR_BIT   = 2;

  function automatic logic [STAT_W-1:0] pack_status(input logic rx_full,
                                                    input logic tx_full,
                                                    input logic ovr,
                                                    input logic tx_pend);
    return {tx_pend, ovr, tx_full, rx_full};
  endfunction

  function automatic logic rise_of(input logic now_v, input logic was_v);
    return now_v & ~was_v;
  endfunction
endpackage

// File: rtl/dbp_sync_edge.sv
module dbp_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_in};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level = chain_q[STAGES-1];
  assign rise  = dbp_pkg::rise_of(chain_q[STAGES-1], prev_q);
endmodule

// File: rtl/dbp_rx_chan.sv
module dbp_rx_chan #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_rise,
  input  logic [DATA_W-1:0] din,
  input  logic              rd_evt,
  input  logic              ovr_clr,
  output logic              full,
  output logic              ovr,
  output logic [DATA_W-1:0] rx_byte
);
  logic capture_evt, blocked_evt;

  assign capture_evt = stb_rise & ~full;
  assign blocked_evt = stb_rise & full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full    <= 1'b0;
      ovr     <= 1'b0;
      rx_byte <= '0;
    end else begin
      if (capture_evt) begin
        full    <= 1'b1;
        rx_byte <= din;
      end else if (rd_evt) begin
        full <= 1'b0;
      end
      if (blocked_evt)  ovr <= 1'b1;
      else if (ovr_clr) ovr <= 1'b0;
    end
  end

  // R3: a strobe against a full buffer leaves the byte untouched
  p_blocked_keeps_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_evt |=> $stable(rx_byte) && full);
  p_blocked_sets_ovr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_evt |=> ovr);
  // R2: reading a full buffer drops it
  p_read_drops_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt && full |=> !full);
  // R1: capture takes the device byte
  p_capture_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> full && rx_byte == $past(din));
endmodule

// File: rtl/dbp_tx_chan.sv
module dbp_tx_chan #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ack_rise,
  output logic              full,
  output logic              pend,
  output logic [DATA_W-1:0] tx_byte
);
  logic load_evt, drain_evt;

  assign load_evt  = wr_evt & ~full;
  assign drain_evt = ack_rise & full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full    <= 1'b0;
      pend    <= 1'b0;
      tx_byte <= '0;
    end else begin
      if (load_evt) begin
        full    <= 1'b1;
        tx_byte <= wdata;
        pend    <= 1'b0;
      end else if (drain_evt) begin
        full <= 1'b0;
        pend <= 1'b1;
      end
    end
  end

  // R4: accepted write loads the byte and raises full
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> full && tx_byte == $past(wdata) && !pend);
  // R5: acknowledge empties the buffer and marks pending
  p_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drain_evt |=> !full && pend);
  // R6: write against a full buffer is ignored
  p_ignore_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt && full |=> $stable(tx_byte));
endmodule

// File: rtl/duplex_byte_port.sv
module duplex_byte_port #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic [1:0]        cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              irq_rx,
  output logic              irq_tx,
  input  logic [DATA_W-1:0] dev_din,
  input  logic              dev_stb,
  output logic              dev_rdy,
  output logic [DATA_W-1:0] dev_dout,
  output logic              dev_bfull,
  input  logic              dev_ack,
  output logic              dev_oe
);
  import dbp_pkg::*;

  logic              stb_level, stb_rise, ack_level, ack_rise;
  logic              rd_data_evt, wr_data_evt, wr_stat_evt, wr_mask_evt;
  logic              rx_full, rx_ovr, tx_full, tx_pend;
  logic [DATA_W-1:0] rx_byte, tx_byte;
  logic [1:0]        mask_q;
  logic [STAT_W-1:0] stat_w;

  assign rd_data_evt = cpu_sel & ~cpu_wr & (cpu_addr == 2'(ADDR_DATA));
  assign wr_data_evt = cpu_sel &  cpu_wr & (cpu_addr == 2'(ADDR_DATA));
  assign wr_stat_evt = cpu_sel &  cpu_wr & (cpu_addr == 2'(ADDR_STAT));
  assign wr_mask_evt = cpu_sel &  cpu_wr & (cpu_addr == 2'(ADDR_MASK));

  dbp_sync_edge #(.STAGES(SYNC_STAGES)) u_stb_sync (
    .clk(clk), .rst_n(rst_n), .async_in(dev_stb), .level(stb_level), .rise(stb_rise));
  dbp_sync_edge #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .async_in(dev_ack), .level(ack_level), .rise(ack_rise));

  dbp_rx_chan #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .stb_rise(stb_rise), .din(dev_din),
    .rd_evt(rd_data_evt), .ovr_clr(wr_stat_evt & cpu_wdata[OVR_BIT]),
    .full(rx_full), .ovr(rx_ovr), .rx_byte(rx_byte));

  dbp_tx_chan #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_data_evt), .wdata(cpu_wdata),
    .ack_rise(ack_rise), .full(tx_full), .pend(tx_pend), .tx_byte(tx_byte));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           mask_q <= '0;
    else if (wr_mask_evt) mask_q <= cpu_wdata[1:0];
  end

  assign stat_w = pack_status(rx_full, tx_full, rx_ovr, tx_pend);

  always_comb begin
    unique case (cpu_addr)
      2'(ADDR_DATA): cpu_rdata = rx_byte;
      2'(ADDR_STAT): cpu_rdata = DATA_W'(stat_w);
      2'(ADDR_MASK): cpu_rdata = DATA_W'(mask_q);
      default:       cpu_rdata = '0;
    endcase
  end

  assign dev_rdy   = rx_full;
  assign dev_bfull = tx_full;
  assign dev_dout  = tx_byte;
  assign dev_oe    = tx_full | ack_level;
  assign irq_rx    = rx_full & mask_q[0];
  assign irq_tx    = tx_pend & mask_q[1];

  // R9: the port drives whenever it flags a full buffer
  p_oe_covers_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dev_bfull |-> dev_oe);
  // R7: a read of a waiting byte removes the receive interrupt
  p_irq_rx_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_evt && irq_rx |=> !irq_rx);
  // R8: an accepted write removes the transmit interrupt
  p_irq_tx_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_evt && !dev_bfull |=> !irq_tx);
  // R1: ready only rises after a synchronised strobe edge
  p_rdy_from_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_rdy) |-> $past(stb_rise));
endmodule

// File: tb/duplex_byte_port_tb_top.sv
module duplex_byte_port_tb_top;
  localparam int CLK_P = 10;
  localparam int DW    = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_sel = 1'b0, cpu_wr = 1'b0;
  logic [1:0]    cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, cpu_rdata;
  logic          irq_rx, irq_tx, dev_rdy, dev_bfull, dev_oe;
  logic [DW-1:0] dev_din = '0, dev_dout;
  logic          dev_stb = 1'b0, dev_ack = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [DW-1:0] tx_exp_q[$];
  logic prev_bfull = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  duplex_byte_port #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .irq_rx(irq_rx), .irq_tx(irq_tx), .dev_din(dev_din), .dev_stb(dev_stb),
    .dev_rdy(dev_rdy), .dev_dout(dev_dout), .dev_bfull(dev_bfull),
    .dev_ack(dev_ack), .dev_oe(dev_oe));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [1:0] a, input logic [DW-1:0] d, input bit expect_load);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    if (expect_load) tx_exp_q.push_back(d);
    @(negedge clk);
    cpu_sel = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_wr = 1'b0; cpu_addr = a;
    #1 d = cpu_rdata;
    @(negedge clk);
    cpu_sel = 1'b0;
  endtask

  task automatic dev_send(input logic [DW-1:0] b);
    @(negedge clk);
    dev_din = b; dev_stb = 1'b1;
    repeat (5) @(negedge clk);
    dev_stb = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // monitor: each new buffer-full must present the next expected byte
  always @(negedge clk) begin
    if (rst_n && dev_bfull && !prev_bfull) begin
      if (tx_exp_q.size() == 0) check(1'b0, "R4 unexpected load", dev_dout, 0);
      else begin
        logic [DW-1:0] e;
        e = tx_exp_q.pop_front();
        check(dev_dout == e, "R4 byte to device", dev_dout, e);
      end
    end
    prev_bfull <= dev_bfull;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check({dev_rdy, dev_bfull, dev_oe, irq_rx, irq_tx} == 5'b0, "R10 outputs", {dev_rdy, dev_bfull, dev_oe, irq_rx, irq_tx}, 0);
    cpu_read(2'd1, r); check(r == 8'h00, "R10 status", r, 0);
    cpu_read(2'd2, r); check(r == 8'h00, "R10 mask", r, 0);

    cpu_write(2'd2, 8'h03, 1'b0);
    // R1 / R7 / R11 receive
    dev_send(8'hA5);
    check(dev_rdy == 1'b1, "R1 ready", dev_rdy, 1);
    check(irq_rx == 1'b1, "R7 irq_rx set", irq_rx, 1);
    cpu_read(2'd1, r); check(r == 8'h01, "R11 status rx full", r, 8'h01);
    cpu_read(2'd0, r); check(r == 8'hA5, "R2 read byte", r, 8'hA5);
    check(dev_rdy == 1'b0, "R2 ready low", dev_rdy, 0);
    check(irq_rx == 1'b0, "R7 irq_rx clear", irq_rx, 0);

    // R3 overrun
    dev_send(8'h3C);
    dev_send(8'hC3);
    cpu_read(2'd1, r); check(r == 8'h05, "R3 overrun set", r, 8'h05);
    cpu_read(2'd0, r); check(r == 8'h3C, "R3 byte kept", r, 8'h3C);
    cpu_write(2'd1, 8'h04, 1'b0);
    cpu_read(2'd1, r); check(r == 8'h00, "R3 overrun clear", r, 0);

    // R4 / R6 / R9 transmit
    cpu_write(2'd0, 8'h5A, 1'b1);
    check(dev_bfull && dev_oe, "R4 bfull and R9 oe", {dev_bfull, dev_oe}, 3);
    cpu_read(2'd1, r); check(r == 8'h02, "R11 status tx full", r, 8'h02);
    cpu_write(2'd0, 8'h77, 1'b0);
    check(dev_dout == 8'h5A, "R6 write ignored", dev_dout, 8'h5A);

    // R5 / R8 / R9 acknowledge
    @(negedge clk); dev_ack = 1'b1;
    repeat (5) @(negedge clk);
    check(dev_bfull == 1'b0, "R5 bfull clear", dev_bfull, 0);
    check(dev_oe == 1'b1, "R9 oe held by ack", dev_oe, 1);
    check(irq_tx == 1'b1, "R8 irq_tx set", irq_tx, 1);
    cpu_read(2'd1, r); check(r == 8'h08, "R5 pending bit", r, 8'h08);
    dev_ack = 1'b0;
    repeat (4) @(negedge clk);
    check(dev_oe == 1'b0, "R9 oe released", dev_oe, 0);

    cpu_write(2'd0, 8'h81, 1'b1);
    check(irq_tx == 1'b0, "R8 irq_tx cleared by write", irq_tx, 0);
    @(negedge clk); dev_ack = 1'b1;
    repeat (5) @(negedge clk);
    dev_ack = 1'b0;
    cpu_write(2'd2, 8'h01, 1'b0);
    check(irq_tx == 1'b0, "R8 masked", irq_tx, 0);
    cpu_read(2'd1, r); check(r == 8'h08, "R8 pending while masked", r, 8'h08);
    repeat (4) @(negedge clk);
    check(tx_exp_q.size() == 0, "R4 all bytes seen", tx_exp_q.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule